// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the serial slave front end of an 8K x 8 byte-wide nonvolatile memory model. A host drives a serial clock, a data input and an active-low select. The engine samples those pins into its own system clock domain, decodes one-byte commands and two-byte addresses, streams array bytes or the status byte back on the serial output, and gathers write data into a one-page buffer. The memory array itself sits outside, behind a simple address, read-data and write-strobe port.

A write to the array or to the status byte is committed only when the select rises exactly on a byte boundary with at least one data byte taken. The write enable latch must also be set. After such a deselect the engine runs a self-timed internal write cycle. First it walks the page buffer and writes every filled slot to the array, one byte per system clock. Then it waits a programmable number of clocks. During that whole time the status byte reads as busy, and every command except a status read is dropped. A separate protection block looks at the array address being written and at the engine's protection fields. It tells the engine which bytes to skip, and whether the status byte may be changed at all.

Top module: `spi_mem_cmd_engine`

## Requirements
- R1: After reset the output enable is low and the write enable latch is clear; a session starts only on a high-to-low change of select seen after reset, so bits clocked while select stayed low through reset do nothing.
- R2: Input bits are taken on rising serial clock edges, output bits change after falling edges, most significant bit first; the output enable is high only while selected and drops within a few system clocks of select going high.
- R3: Command 0x03 followed by a 16-bit address (only the low 13 bits used) streams array bytes from that address, incrementing after each byte and wrapping from 0x1FFF to 0x0000.
- R4: Command 0x06 sets the write enable latch and command 0x04 clears it, each only if select rises right after the eighth bit; one more clock before deselect cancels it.
- R5: Command 0x02 plus address and data commits only if select rises on a byte boundary after at least one data byte with the latch set; any other deselect leaves the array and the latch unchanged.
- R6: Data bytes of one write go to consecutive offsets inside a 32-byte page and wrap to the start of that page, so later bytes overwrite earlier ones; bytes outside the page are untouched.
- R7: Command 0x05 returns the status byte with protect-enable at bit 7, zeros at bits 6..4, the two block-protect bits at bits 3..2, the write enable latch at bit 1 and write-in-progress at bit 0, repeated while clocked; during an internal write cycle it reads 0xFF.
- R8: Command 0x01 with one data byte, a committing deselect, the latch set and `prot_sr_lock` low copies data bits 7, 3 and 2 to `cfg_wpen` and `cfg_bp`; with `prot_sr_lock` high they stay unchanged.
- R9: A committed array write keeps write-in-progress at 1 for 32 + WR_CYCLES system clocks, a status write for WR_CYCLES; afterwards write-in-progress and the write enable latch are both 0.
- R10: While write-in-progress is 1, any command other than 0x05 is ignored until select next rises, so a write issued then changes nothing.
- R11: A buffered byte whose array address `prot_deny` flags during the internal cycle is not written; the other bytes of the page are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for the serial data out driver |
| mem_addr | output | 13 | Array address for reads and for internal writes |
| mem_rdata | input | 8 | Array read data for `mem_addr`, combinational |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| prot_deny | input | 1 | High when `mem_addr` may not be written |
| prot_sr_lock | input | 1 | High when the status byte may not be written |
| cfg_wpen | output | 1 | Stored protect-enable bit |
| cfg_bp | output | 2 | Stored block-protect field |

## Verification
A serial clock or select change reaches the decode logic three system clocks later: two synchronizer stages plus the edge register. A serial output bit appears one clock after that, so it is valid about four clocks after a falling edge. The bench holds each serial clock level for six system clocks and samples the output just before the next rising edge. It waits at least three half-periods after every deselect before it looks at the output enable or the protection outputs. The internal write cycle ends 32 + WR_CYCLES clocks after the commit. The bench reads the status once early inside that window, expecting 0xFF, and once well after it, expecting the latch and busy flag cleared.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
   localparam logic [7:0] CMD_WREN  = 8'h06;
   localparam logic [7:0] CMD_WRDI  = 8'h04;
   localparam logic [7:0] CMD_RDSR  = 8'h05;
   localparam logic [7:0] CMD_WRSR  = 8'h01;
   localparam logic [7:0] CMD_READ  = 8'h03;
   localparam logic [7:0] CMD_WRITE = 8'h02;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_OP,
      PH_ADDR,
      PH_RD,
      PH_WR,
      PH_SROUT,
      PH_SRIN,
      PH_WEN,
      PH_WDIS,
      PH_SKIP
   } phase_e;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
   parameter int              WIDTH   = 3,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_mem_sync needs at least two stages");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] r;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= g_stage[s-1].r;
         end
      end
   end

   assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/spi_mem_wcyc.sv
module spi_mem_wcyc #(
   parameter int ADDR_W    = 13,
   parameter int PAGE_W    = 5,
   parameter int WR_CYCLES = 64
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_buf,
   input  logic                     buf_we,
   input  logic [PAGE_W-1:0]        buf_idx,
   input  logic [7:0]               buf_data,
   input  logic                     go_array,
   input  logic                     go_status,
   input  logic [ADDR_W-PAGE_W-1:0] page_base,
   output logic                     busy,
   output logic                     done,
   output logic                     wr_en,
   output logic [ADDR_W-1:0]        wr_addr,
   output logic [7:0]               wr_data
);
   localparam int DEPTH  = 1 << PAGE_W;
   localparam int BASE_W = ADDR_W - PAGE_W;
   localparam int CNT_W  = (WR_CYCLES < 2) ? 1 : $clog2(WR_CYCLES);

   if (WR_CYCLES < 1) begin : g_bad_cycles
      $error("spi_mem_wcyc needs WR_CYCLES of at least one");
   end

   typedef enum logic [1:0] {WS_IDLE, WS_FLUSH, WS_WAIT} wstate_e;

   wstate_e            st;
   logic [7:0]         pbuf [DEPTH];
   logic [DEPTH-1:0]   vld;
   logic [PAGE_W-1:0]  idx;
   logic [CNT_W-1:0]   tmr;
   logic [BASE_W-1:0]  base;

   always_ff @(posedge clk) begin
      if (buf_we) pbuf[buf_idx] <= buf_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
      end else if (clr_buf) begin
         vld <= '0;
      end else if (buf_we) begin
         vld[buf_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= WS_IDLE;
         idx  <= '0;
         tmr  <= '0;
         base <= '0;
      end else begin
         case (st)
            WS_IDLE: begin
               if (go_array) begin
                  st   <= WS_FLUSH;
                  idx  <= '0;
                  base <= page_base;
               end else if (go_status) begin
                  st  <= WS_WAIT;
                  tmr <= '0;
               end
            end
            WS_FLUSH: begin
               idx <= idx + 1'b1;
               if (idx == '1) begin
                  st  <= WS_WAIT;
                  tmr <= '0;
               end
            end
            WS_WAIT: begin
               tmr <= tmr + 1'b1;
               if (tmr == CNT_W'(WR_CYCLES - 1)) st <= WS_IDLE;
            end
            default: st <= WS_IDLE;
         endcase
      end
   end

   assign busy    = (st != WS_IDLE);
   assign done    = (st == WS_WAIT) && (tmr == CNT_W'(WR_CYCLES - 1));
   assign wr_en   = (st == WS_FLUSH) && vld[idx];
   assign wr_addr = {base, idx};
   assign wr_data = pbuf[idx];

   // R10: the command decoder never fills the page buffer during a cycle
   p_no_fill_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !buf_we);
   // R9: a cycle never restarts while one is running
   p_single_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(go_array || go_status));
endmodule

// File: rtl/spi_mem_cmd_engine.sv
module spi_mem_cmd_engine
   import spi_mem_pkg::*;
#(
   parameter int ADDR_W      = 13,
   parameter int PAGE_W      = 5,
   parameter int WR_CYCLES   = 64,
   parameter int SYNC_STAGES = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_si,
   output logic              spi_so,
   output logic              spi_so_oe,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rdata,
   output logic              mem_we,
   output logic [7:0]        mem_wdata,
   input  logic              prot_deny,
   input  logic              prot_sr_lock,
   output logic              cfg_wpen,
   output logic [1:0]        cfg_bp
);
   localparam int BASE_W = ADDR_W - PAGE_W;
   localparam int HI_W   = ADDR_W - 8;

   if (ADDR_W <= 8 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie in 9..16");
   end
   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("PAGE_W must be below ADDR_W");
   end

   // pin synchronizers: bit 2 select, bit 1 clock, bit 0 data
   logic [2:0] pins_q;
   spi_mem_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_cs_n, spi_sck, spi_si}),
      .q     (pins_q)
   );

   logic cs_q, sck_q, si_q, cs_d, sck_d;
   logic sck_rise, sck_fall, cs_rise, cs_fall;
   assign cs_q     = pins_q[2];
   assign sck_q    = pins_q[1];
   assign si_q     = pins_q[0];
   assign sck_rise = sck_q & ~sck_d;
   assign sck_fall = ~sck_q & sck_d;
   assign cs_rise  = cs_q & ~cs_d;
   assign cs_fall  = ~cs_q & cs_d;

   phase_e             phase;
   logic               active;
   logic [2:0]         bit_idx;
   logic [6:0]         shreg;
   logic [HI_W-1:0]    addr_hi;
   logic               addr_second;
   logic               is_write;
   logic [ADDR_W-1:0]  rd_addr;
   logic [PAGE_W-1:0]  wr_off;
   logic [BASE_W-1:0]  page_base;
   logic               got_byte;
   logic [7:0]         out_byte;
   logic [2:0]         out_idx;
   logic               so_q;
   logic               load_rd;
   logic               wel, wpen, new_wpen;
   logic [1:0]         bp, new_bp;

   logic [7:0]         in_byte;
   logic [ADDR_W-1:0]  full_addr;
   logic [7:0]         st_byte;
   logic               byte_end;
   logic               wen_ok, wdis_ok, ar_go, sr_go;
   logic               buf_we, clr_buf;
   logic               wc_busy, wc_done, wc_en;
   logic [ADDR_W-1:0]  wc_addr;
   logic [7:0]         wc_data;

   assign in_byte   = {shreg, si_q};
   assign full_addr = {addr_hi, in_byte};
   assign st_byte   = wc_busy ? 8'hFF : {wpen, 3'b000, bp, wel, 1'b0};
   assign byte_end  = active && sck_rise && (bit_idx == 3'd7);

   assign wen_ok  = cs_rise && active && (phase == PH_WEN);
   assign wdis_ok = cs_rise && active && (phase == PH_WDIS);
   assign ar_go   = cs_rise && active && (phase == PH_WR) && (bit_idx == 3'd0)
                    && got_byte && wel;
   assign sr_go   = cs_rise && active && (phase == PH_SRIN) && (bit_idx == 3'd0)
                    && got_byte && wel && !prot_sr_lock;
   assign buf_we  = byte_end && (phase == PH_WR);
   assign clr_buf = byte_end && (phase == PH_OP) && (in_byte == CMD_WRITE) && !wc_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d       <= 1'b0;
         cs_d        <= 1'b0;
         active      <= 1'b0;
         phase       <= PH_IDLE;
         bit_idx     <= '0;
         shreg       <= '0;
         addr_hi     <= '0;
         addr_second <= 1'b0;
         is_write    <= 1'b0;
         rd_addr     <= '0;
         wr_off      <= '0;
         page_base   <= '0;
         got_byte    <= 1'b0;
         out_byte    <= '0;
         out_idx     <= '0;
         so_q        <= 1'b0;
         load_rd     <= 1'b0;
         wel         <= 1'b0;
         wpen        <= 1'b0;
         bp          <= '0;
         new_wpen    <= 1'b0;
         new_bp      <= '0;
      end else begin
         sck_d   <= sck_q;
         cs_d    <= cs_q;
         load_rd <= 1'b0;
         if (load_rd) out_byte <= mem_rdata;
         if (wc_done) wel <= 1'b0;

         if (cs_fall) begin
            active   <= 1'b1;
            phase    <= PH_OP;
            bit_idx  <= '0;
            got_byte <= 1'b0;
            out_idx  <= '0;
            so_q     <= 1'b0;
         end else if (cs_rise) begin
            active <= 1'b0;
            phase  <= PH_IDLE;
            if (wen_ok)  wel <= 1'b1;
            if (wdis_ok) wel <= 1'b0;
            if (sr_go) begin
               wpen <= new_wpen;
               bp   <= new_bp;
            end
         end else if (active && sck_rise) begin
            bit_idx <= bit_idx + 3'd1;
            shreg   <= in_byte[6:0];
            if (phase == PH_WEN || phase == PH_WDIS) begin
               phase <= PH_SKIP;
            end else if (bit_idx == 3'd7) begin
               case (phase)
                  PH_OP: begin
                     if (wc_busy && in_byte != CMD_RDSR) begin
                        phase <= PH_SKIP;
                     end else begin
                        case (in_byte)
                           CMD_WREN: phase <= PH_WEN;
                           CMD_WRDI: phase <= PH_WDIS;
                           CMD_RDSR: begin
                              phase    <= PH_SROUT;
                              out_byte <= st_byte;
                              out_idx  <= '0;
                           end
                           CMD_WRSR: phase <= PH_SRIN;
                           CMD_READ: begin
                              phase       <= PH_ADDR;
                              is_write    <= 1'b0;
                              addr_second <= 1'b0;
                           end
                           CMD_WRITE: begin
                              phase       <= PH_ADDR;
                              is_write    <= 1'b1;
                              addr_second <= 1'b0;
                           end
                           default: phase <= PH_SKIP;
                        endcase
                     end
                  end
                  PH_ADDR: begin
                     if (!addr_second) begin
                        addr_hi     <= in_byte[HI_W-1:0];
                        addr_second <= 1'b1;
                     end else if (is_write) begin
                        phase     <= PH_WR;
                        wr_off    <= full_addr[PAGE_W-1:0];
                        page_base <= full_addr[ADDR_W-1:PAGE_W];
                     end else begin
                        phase   <= PH_RD;
                        rd_addr <= full_addr;
                        load_rd <= 1'b1;
                        out_idx <= '0;
                     end
                  end
                  PH_WR: begin
                     wr_off   <= wr_off + 1'b1;
                     got_byte <= 1'b1;
                  end
                  PH_SRIN: begin
                     new_wpen <= in_byte[7];
                     new_bp   <= in_byte[3:2];
                     got_byte <= 1'b1;
                  end
                  default: ;
               endcase
            end
         end else if (active && sck_fall && (phase == PH_RD || phase == PH_SROUT)) begin
            so_q    <= out_byte[3'd7 - out_idx];
            out_idx <= out_idx + 3'd1;
            if (out_idx == 3'd7) begin
               if (phase == PH_RD) begin
                  rd_addr <= rd_addr + 1'b1;
                  load_rd <= 1'b1;
               end else begin
                  out_byte <= st_byte;
               end
            end
         end
      end
   end

   spi_mem_wcyc #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_wcyc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_buf   (clr_buf),
      .buf_we    (buf_we),
      .buf_idx   (wr_off),
      .buf_data  (in_byte),
      .go_array  (ar_go),
      .go_status (sr_go),
      .page_base (page_base),
      .busy      (wc_busy),
      .done      (wc_done),
      .wr_en     (wc_en),
      .wr_addr   (wc_addr),
      .wr_data   (wc_data)
   );

   assign mem_addr  = wc_busy ? wc_addr : rd_addr;
   assign mem_we    = wc_en & ~prot_deny;
   assign mem_wdata = wc_data;
   assign spi_so    = so_q;
   assign spi_so_oe = active;
   assign cfg_wpen  = wpen;
   assign cfg_bp    = bp;

   // R1: the output driver only turns on after a seen select fall
   p_arm_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_so_oe) |-> $past(cs_fall));
   // R2: deselected for two cycles means the driver is off
   p_oe_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_q && $past(cs_q)) |-> !spi_so_oe);
   // R4: the latch only sets at a deselect
   p_wen_at_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(cs_rise));
   // R5: an internal cycle starts only after an aligned deselect with data
   p_commit_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wc_busy) |-> $past(cs_rise && bit_idx == 3'd0 && got_byte && wel));
   // R9: the latch is clear once the cycle ends
   p_wel_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wc_done |=> !wel);
   // R11: a flagged address never gets a write strobe
   p_deny_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      prot_deny |-> !mem_we);
endmodule

// File: tb/spi_mem_cmd_engine_test.sv
module spi_mem_cmd_engine_test;
   localparam int HP  = 6;
   localparam int WRC = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0;
   logic cs_n = 1'b0;
   logic si = 1'b0;
   logic so, so_oe, mem_we, prot_sr_lock, deny_on, cfg_wpen;
   logic [12:0] mem_addr;
   logic [7:0]  mem_rdata, mem_wdata;
   logic [1:0]  cfg_bp;
   logic        prot_deny;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [7:0] mem   [0:8191];
   bit         wflag [0:8191];
   logic [7:0] rbuf  [0:63];

   always #10 clk = ~clk;

   function automatic logic [7:0] init_val(input int a);
      return 8'((a * 7 + 3) ^ (a >> 5));
   endfunction

   always @(posedge clk) begin
      if (mem_we) begin
         mem[mem_addr]   <= mem_wdata;
         wflag[mem_addr] <= 1'b1;
      end
   end
   assign mem_rdata = wflag[mem_addr] ? mem[mem_addr] : init_val(int'(mem_addr));
   assign prot_deny = deny_on && (mem_addr[12:4] == 9'h050);

   spi_mem_cmd_engine #(.WR_CYCLES(WRC)) uut (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
      .spi_so(so), .spi_so_oe(so_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .prot_deny(prot_deny),
      .prot_sr_lock(prot_sr_lock), .cfg_wpen(cfg_wpen), .cfg_bp(cfg_bp)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sel();
      cs_n = 1'b0;
      wait_clk(2 * HP);
   endtask

   task automatic desel();
      wait_clk(HP);
      cs_n = 1'b1;
      wait_clk(3 * HP);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int nbits);
      rx = '0;
      for (int b = 7; b > 7 - nbits; b--) begin
         si = tx[b];
         wait_clk(HP);
         rx[b] = so;
         sck = 1'b1;
         wait_clk(HP);
         sck = 1'b0;
      end
   endtask

   task automatic send(input logic [7:0] tx);
      logic [7:0] dummy;
      xfer(tx, dummy, 8);
   endtask

   task automatic one_cmd(input logic [7:0] op);
      sel(); send(op); desel();
   endtask

   task automatic rdsr(output logic [7:0] v);
      sel(); send(8'h05); xfer(8'h00, v, 8); desel();
   endtask

   task automatic rd_block(input logic [15:0] a, input int n);
      logic [7:0] v;
      sel(); send(8'h03); send(a[15:8]); send(a[7:0]);
      for (int k = 0; k < n; k++) begin
         xfer(8'h00, v, 8);
         rbuf[k] = v;
      end
      desel();
   endtask

   task automatic wait_cycle();
      wait_clk(32 + WRC + 40);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check("R1 oe low after reset", 16'(so_oe), 16'h0);
      send(8'h06);
      check("R1 oe low without select fall", 16'(so_oe), 16'h0);
      cs_n = 1'b1;
      wait_clk(3 * HP);
      rdsr(v);
      check("R1 command before first select fall ignored", 16'(v), 16'h00);
      check("R2 oe low when deselected", 16'(so_oe), 16'h0);
   endtask

   task automatic t_latch();
      logic [7:0] v;
      sel(); send(8'h06); xfer(8'h00, v, 1); desel();
      rdsr(v);
      check("R4 extra clock cancels set", 16'(v), 16'h00);
      one_cmd(8'h06);
      rdsr(v);
      check("R4 set latch, R7 bit1", 16'(v), 16'h02);
      sel(); send(8'h04); xfer(8'h00, v, 1); desel();
      rdsr(v);
      check("R4 extra clock cancels clear", 16'(v), 16'h02);
      one_cmd(8'h04);
      rdsr(v);
      check("R4 clear latch", 16'(v), 16'h00);
      sel(); send(8'h05); xfer(8'h00, v, 8);
      check("R2 oe high while selected", 16'(so_oe), 16'h1);
      xfer(8'h00, v, 8); desel();
      check("R7 status repeats", 16'(v), 16'h00);
   endtask

   task automatic t_write_read();
      logic [7:0] v;
      one_cmd(8'h06);
      sel(); send(8'h02); send(8'h01); send(8'h05);
      send(8'hA5); send(8'h5A); send(8'hC3); desel();
      rdsr(v);
      check("R7 R9 busy status 0xFF", 16'(v), 16'hFF);
      wait_cycle();
      rdsr(v);
      check("R9 busy and latch clear after cycle", 16'(v), 16'h00);
      rd_block(16'hE105, 4);
      check("R3 R5 byte0 high address bits ignored", 16'(rbuf[0]), 16'hA5);
      check("R3 R5 byte1", 16'(rbuf[1]), 16'h5A);
      check("R3 R5 byte2", 16'(rbuf[2]), 16'hC3);
      check("R3 auto increment past data", 16'(rbuf[3]), 16'(init_val(16'h0108)));
      rd_block(16'h1FFE, 4);
      check("R3 read 0x1FFE", 16'(rbuf[0]), 16'(init_val(16'h1FFE)));
      check("R3 read 0x1FFF", 16'(rbuf[1]), 16'(init_val(16'h1FFF)));
      check("R3 wrap to 0x0000", 16'(rbuf[2]), 16'(init_val(0)));
      check("R3 then 0x0001", 16'(rbuf[3]), 16'(init_val(1)));
   endtask

   task automatic t_abort();
      logic [7:0] v;
      one_cmd(8'h06);
      sel(); send(8'h02); send(8'h02); send(8'h00); send(8'h11);
      xfer(8'h22, v, 3); desel();
      rdsr(v);
      check("R5 misaligned deselect no cycle, latch kept", 16'(v), 16'h02);
      sel(); send(8'h02); send(8'h02); send(8'h00); desel();
      rdsr(v);
      check("R5 no data byte no cycle", 16'(v), 16'h02);
      rd_block(16'h0200, 1);
      check("R5 array unchanged", 16'(rbuf[0]), 16'(init_val(16'h0200)));
      one_cmd(8'h04);
      sel(); send(8'h02); send(8'h02); send(8'h00); send(8'h33); desel();
      rdsr(v);
      check("R5 latch clear blocks write", 16'(v), 16'h00);
      rd_block(16'h0200, 1);
      check("R5 array unchanged without latch", 16'(rbuf[0]), 16'(init_val(16'h0200)));
   endtask

   task automatic t_page();
      one_cmd(8'h06);
      sel(); send(8'h02); send(8'h04); send(8'h00);
      for (int k = 0; k < 34; k++) send(8'(8'h10 + k));
      desel();
      wait_cycle();
      rd_block(16'h0400, 33);
      check("R6 offset0 overwritten", 16'(rbuf[0]), 16'h30);
      check("R6 offset1 overwritten", 16'(rbuf[1]), 16'h31);
      check("R6 offset2 kept", 16'(rbuf[2]), 16'h12);
      check("R6 offset31", 16'(rbuf[31]), 16'h2F);
      check("R6 next page untouched", 16'(rbuf[32]), 16'(init_val(16'h0420)));
      one_cmd(8'h06);
      sel(); send(8'h02); send(8'h03); send(8'h1E);
      send(8'hA0); send(8'hA1); send(8'hA2); desel();
      wait_cycle();
      rd_block(16'h0300, 1);
      check("R6 wrap to page start", 16'(rbuf[0]), 16'hA2);
      rd_block(16'h031E, 3);
      check("R6 last offsets", 16'({rbuf[0], rbuf[1]}), 16'hA0A1);
      check("R6 0x320 untouched", 16'(rbuf[2]), 16'(init_val(16'h0320)));
   endtask

   task automatic t_busy_ignore();
      one_cmd(8'h06);
      sel(); send(8'h02); send(8'h06); send(8'h00); send(8'h77); desel();
      sel(); send(8'h02); send(8'h06); send(8'h10); send(8'h88); desel();
      wait_cycle();
      rd_block(16'h0600, 1);
      check("R5 first write landed", 16'(rbuf[0]), 16'h77);
      rd_block(16'h0610, 1);
      check("R10 write during cycle ignored", 16'(rbuf[0]), 16'(init_val(16'h0610)));
   endtask

   task automatic t_status_write();
      logic [7:0] v;
      one_cmd(8'h06);
      sel(); send(8'h01); send(8'h8C); desel();
      check("R8 protect fields stored", 16'({cfg_wpen, cfg_bp}), 16'h7);
      wait_cycle();
      rdsr(v);
      check("R7 R8 status layout", 16'(v), 16'h8C);
      prot_sr_lock = 1'b1;
      one_cmd(8'h06);
      sel(); send(8'h01); send(8'h00); desel();
      check("R8 lock keeps fields", 16'({cfg_wpen, cfg_bp}), 16'h7);
      rdsr(v);
      check("R8 lock no cycle", 16'(v), 16'h8E);
      prot_sr_lock = 1'b0;
      sel(); send(8'h01); send(8'h04); desel();
      check("R8 unlocked write", 16'({cfg_wpen, cfg_bp}), 16'h1);
      wait_cycle();
   endtask

   task automatic t_deny();
      deny_on = 1'b1;
      one_cmd(8'h06);
      sel(); send(8'h02); send(8'h05); send(8'h0E);
      send(8'hD0); send(8'hD1); send(8'hD2); send(8'hD3); desel();
      wait_cycle();
      deny_on = 1'b0;
      rd_block(16'h050E, 4);
      check("R11 denied 0x50E", 16'(rbuf[0]), 16'(init_val(16'h050E)));
      check("R11 denied 0x50F", 16'(rbuf[1]), 16'(init_val(16'h050F)));
      check("R11 allowed 0x510", 16'(rbuf[2]), 16'hD2);
      check("R11 allowed 0x511", 16'(rbuf[3]), 16'hD3);
   endtask

   initial begin
      prot_sr_lock = 1'b0;
      deny_on = 1'b0;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_latch();
      t_write_read();
      t_abort();
      t_page();
      t_busy_ignore();
      t_status_write();
      t_deny();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule